// File: doc/BRIEF.md
# Stop-Mode Wake Controller

This block decides when the processor core of a small low-power device sleeps, what stays powered while it sleeps, and how it comes back. On a stop request it holds the core, gates the serial-bus controller and, if the retention sub-mode is configured, cuts power to the volatile domains. The volatile domains are core state and the bus and crypto buffers. Only the low 256 words of data memory stay powered. The power monitor stays on during stop unless software disabled it for the stop period.

Wake requests come from several sources: interrupt lines that are enabled, a monitor warning, a monitor reset, an external reset, a brown-out to the power-on-reset level, and an expiry of a down-counting wake timer. The bus side has its own path. A normal-speed bus reset pulse powers up only the bus controller for a bounded listening window. The core wakes only if the controller reports that the device was addressed; otherwise the device goes back to stop. On every exit the monitor runs for a fixed settle window before the core is released. At the end of that window the supply is judged once. A warning sets the power-fail interrupt flag, and a reset-level supply resets the core. Leaving the retention sub-mode always requests a power-on reset.

Top module: `stop_wake_ctrl`

## Requirements
- R1: After the synchronous reset the core runs (`cpu_run`=1), with `mon_en`=1, `ow_pwr`=1, `volatile_pd`=0, and `cpu_rst`, `por_req` and `pf_flag` all 0.
- R2: A `stop_req` seen while running, with neither `vdd_lt_rst` nor `ext_rst` high, enters stop on the next edge. In stop, `cpu_run`=0 and `ow_pwr`=0. `mon_en` is the inverse of `cfg_pfd`, and `volatile_pd` equals `cfg_dret` AND NOT `cfg_regen`; both values are sampled at the request.
- R3: In stop, any one of these wakes the block on the next edge: an interrupt line high with its enable bit set, `ext_rst`, `vdd_lt_por`, a wake-timer expiry, `vdd_lt_rst` with the monitor on, or `vdd_lt_warn` with the monitor on and `pfw_en`=1. Waking starts the exit window, during which `cpu_run`=0, `mon_en`=1, `ow_pwr`=1 and `volatile_pd`=0.
- R4: With the monitor off (`cfg_pfd`=1 at entry), `vdd_lt_warn` and `vdd_lt_rst` do not wake the block and `mon_en` stays 0, but `vdd_lt_por` still wakes it.
- R5: The exit window lasts exactly SETTLE_CYC cycles; `cpu_run` rises on the cycle after the last one.
- R6: The supply is judged on the last cycle of the exit window. If `vdd_lt_warn` is high, `pf_flag` is set. If `vdd_lt_rst` is high, or an `ext_rst` was seen since stop entry, `cpu_rst` is 1 in the first cycle of running.
- R7: Leaving the retention sub-mode gives `por_req`=1 for one cycle, in the first cycle of running. Leaving plain stop gives no `por_req` unless `vdd_lt_por` was high.
- R8: `vdd_lt_por` high in any cycle gives `por_req`=1 in the next cycle.
- R9: The wake timer is loaded from `wake_period` at stop entry. For a period P≥1, with no other source, stop lasts exactly P cycles. P=0 disables the timer.
- R10: In stop, a reset pulse with `ow_pulse_od`=0 raises `ow_pwr` on the next edge while `cpu_run` stays 0. `ow_addressed` during the OW_WIN-cycle listening window wakes the block. Without it, `ow_pwr` falls after OW_WIN cycles and stop continues.
- R11: In stop, a reset pulse with `ow_pulse_od`=1 is ignored: `ow_pwr` stays 0.
- R12: While running, `vdd_lt_rst` or `ext_rst` gives `cpu_rst`=1 on the next cycle and drops a `stop_req` seen in the same cycle. `vdd_lt_warn` sets `pf_flag`. `pf_clr` clears `pf_flag` unless a set happens in the same cycle.
- R13: An interrupt line whose `irq_en` bit is 0 does not wake the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stop_req | input | 1 | Request to enter stop |
| cfg_dret | input | 1 | Retention sub-mode select |
| cfg_regen | input | 1 | Regulator kept on during stop (blocks retention) |
| cfg_pfd | input | 1 | Disable the power monitor during stop |
| pfw_en | input | 1 | Power-fail warning is a wake source |
| irq_en | input | NIRQ | Per-line interrupt wake enables |
| irq_req | input | NIRQ | Interrupt wake requests |
| wake_period | input | TMR_W | Wake-timer period, 0 = off |
| vdd_lt_warn | input | 1 | Supply below warning threshold |
| vdd_lt_rst | input | 1 | Supply below reset threshold |
| vdd_lt_por | input | 1 | Supply below power-on-reset level |
| ext_rst | input | 1 | External reset request |
| ow_rst_pulse | input | 1 | Bus reset pulse detected |
| ow_pulse_od | input | 1 | Detected pulse was overdrive length |
| ow_addressed | input | 1 | Bus controller reports the device was addressed |
| pf_clr | input | 1 | Clear the power-fail interrupt flag |
| cpu_run | output | 1 | Core may execute |
| pf_flag | output | 1 | Power-fail interrupt flag |
| cpu_rst | output | 1 | Core reset pulse |
| por_req | output | 1 | Power-on reset request |
| mon_en | output | 1 | Power monitor enable |
| volatile_pd | output | 1 | Power-down of core state and bus/crypto buffers |
| ow_pwr | output | 1 | Bus controller power gate |

## Verification
The hardest state to reach is an unaddressed bus reset during retention stop. The listening window has to run out and the device has to fall back to stop without the timer or any other source interfering. A later addressed reset on the same stop must then still produce a power-on reset at exit. The stimulus sets a zero timer period so nothing else can wake the block, sends an overdrive pulse first and then a normal one, and lets the window expire. It then repeats the normal pulse and raises the address indication part way through the window. A behavioural model tracks every output on every cycle alongside these directed checks.

// File: rtl/swc_pkg.sv
package swc_pkg;
  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_STOP   = 2'd1,
    ST_OWCHK  = 2'd2,
    ST_SETTLE = 2'd3
  } swc_state_e;

  typedef struct packed {
    logic retain;   // retention sub-mode taken at stop entry
    logic mon_off;  // monitor disabled for this stop period
  } stop_cfg_t;
endpackage

// File: rtl/swc_dcount.sv
// Loadable down-counter; last is high while the count equals one.
module swc_dcount #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         en,
  output logic         last
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (en && (cnt != '0)) begin
      cnt <= cnt - W'(1);
    end
  end

  assign last = (cnt == W'(1));
endmodule

// File: rtl/swc_wake_merge.sv
// Combines all wake sources; only meaningful while the block sleeps.
module swc_wake_merge #(
  parameter int NIRQ = 4
) (
  input  logic            asleep,
  input  logic            in_owchk,
  input  logic            mon_on,
  input  logic            pfw_en,
  input  logic [NIRQ-1:0] irq_req,
  input  logic [NIRQ-1:0] irq_en,
  input  logic            vdd_lt_warn,
  input  logic            vdd_lt_rst,
  input  logic            vdd_lt_por,
  input  logic            ext_rst,
  input  logic            tmr_last,
  input  logic            ow_addressed,
  output logic            wake
);
  logic [NIRQ-1:0] irq_hit;
  logic            mon_hit;
  logic            src_any;

  genvar gi;
  generate
    for (gi = 0; gi < NIRQ; gi++) begin : g_irq
      assign irq_hit[gi] = irq_req[gi] & irq_en[gi];
    end
  endgenerate

  assign mon_hit = mon_on & ((pfw_en & vdd_lt_warn) | vdd_lt_rst);
  assign src_any = (|irq_hit) | mon_hit | vdd_lt_por | ext_rst | tmr_last
                 | (in_owchk & ow_addressed);
  assign wake    = asleep & src_any;
endmodule

// File: rtl/stop_wake_ctrl.sv
module stop_wake_ctrl
  import swc_pkg::*;
#(
  parameter int NIRQ       = 4,
  parameter int TMR_W      = 16,
  parameter int SETTLE_CYC = 4,
  parameter int OW_WIN     = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stop_req,
  input  logic             cfg_dret,
  input  logic             cfg_regen,
  input  logic             cfg_pfd,
  input  logic             pfw_en,
  input  logic [NIRQ-1:0]  irq_en,
  input  logic [NIRQ-1:0]  irq_req,
  input  logic [TMR_W-1:0] wake_period,
  input  logic             vdd_lt_warn,
  input  logic             vdd_lt_rst,
  input  logic             vdd_lt_por,
  input  logic             ext_rst,
  input  logic             ow_rst_pulse,
  input  logic             ow_pulse_od,
  input  logic             ow_addressed,
  input  logic             pf_clr,
  output logic             cpu_run,
  output logic             pf_flag,
  output logic             cpu_rst,
  output logic             por_req,
  output logic             mon_en,
  output logic             volatile_pd,
  output logic             ow_pwr
);
  localparam int SET_W = $clog2(SETTLE_CYC + 1);
  localparam int OW_W  = $clog2(OW_WIN + 1);

  swc_state_e st, st_nxt;
  stop_cfg_t  cfg_l;
  logic       ext_seen;
  logic       asleep, in_owchk, in_settle, wake, ow_norm;
  logic       tmr_last, set_last, ow_last;
  logic       run_fault, enter_stop, judge, ow_start;
  logic       cpu_rst_q, por_q, pf_q;

  assign asleep     = (st == ST_STOP) || (st == ST_OWCHK);
  assign in_owchk   = (st == ST_OWCHK);
  assign in_settle  = (st == ST_SETTLE);
  assign ow_norm    = ow_rst_pulse & ~ow_pulse_od;
  assign run_fault  = vdd_lt_rst | ext_rst;
  assign enter_stop = (st == ST_RUN) && stop_req && !run_fault;
  assign judge      = in_settle && set_last;
  assign ow_start   = (st == ST_STOP) && !wake && ow_norm;

  swc_wake_merge #(.NIRQ(NIRQ)) u_merge (
    .asleep      (asleep),
    .in_owchk    (in_owchk),
    .mon_on      (~cfg_l.mon_off),
    .pfw_en      (pfw_en),
    .irq_req     (irq_req),
    .irq_en      (irq_en),
    .vdd_lt_warn (vdd_lt_warn),
    .vdd_lt_rst  (vdd_lt_rst),
    .vdd_lt_por  (vdd_lt_por),
    .ext_rst     (ext_rst),
    .tmr_last    (tmr_last),
    .ow_addressed(ow_addressed),
    .wake        (wake)
  );

  // wake timer: loaded on entry, runs through stop and listening
  swc_dcount #(.W(TMR_W)) u_wake_tmr (
    .clk(clk), .rst(rst), .load(enter_stop), .load_val(wake_period),
    .en(asleep), .last(tmr_last)
  );

  // exit settle window
  swc_dcount #(.W(SET_W)) u_settle (
    .clk(clk), .rst(rst), .load(asleep && wake), .load_val(SET_W'(SETTLE_CYC)),
    .en(in_settle), .last(set_last)
  );

  // bus listening window
  swc_dcount #(.W(OW_W)) u_ow_win (
    .clk(clk), .rst(rst), .load(ow_start), .load_val(OW_W'(OW_WIN)),
    .en(in_owchk), .last(ow_last)
  );

  always_comb begin
    st_nxt = st;
    case (st)
      ST_RUN:    if (enter_stop) st_nxt = ST_STOP;
      ST_STOP:   if (wake) st_nxt = ST_SETTLE;
                 else if (ow_norm) st_nxt = ST_OWCHK;
      ST_OWCHK:  if (wake) st_nxt = ST_SETTLE;
                 else if (ow_last) st_nxt = ST_STOP;
      ST_SETTLE: if (set_last) st_nxt = ST_RUN;
      default:   st_nxt = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_RUN;
      cfg_l     <= '0;
      ext_seen  <= 1'b0;
      cpu_rst_q <= 1'b0;
      por_q     <= 1'b0;
      pf_q      <= 1'b0;
    end else begin
      st <= st_nxt;
      if (enter_stop) begin
        cfg_l.retain  <= cfg_dret & ~cfg_regen;
        cfg_l.mon_off <= cfg_pfd;
      end
      if (enter_stop)
        ext_seen <= 1'b0;
      else if ((st != ST_RUN) && ext_rst)
        ext_seen <= 1'b1;
      cpu_rst_q <= ((st == ST_RUN) && run_fault)
                 || (judge && (vdd_lt_rst || ext_seen || ext_rst));
      por_q     <= vdd_lt_por || (judge && cfg_l.retain);
      if (((st == ST_RUN) || judge) && vdd_lt_warn)
        pf_q <= 1'b1;
      else if (pf_clr)
        pf_q <= 1'b0;
    end
  end

  assign cpu_run     = (st == ST_RUN);
  assign mon_en      = (st == ST_RUN) || in_settle || (asleep && !cfg_l.mon_off);
  assign ow_pwr      = (st != ST_STOP);
  assign volatile_pd = asleep && cfg_l.retain;
  assign cpu_rst     = cpu_rst_q;
  assign por_req     = por_q;
  assign pf_flag     = pf_q;
endmodule

// File: rtl/swc_checker.sv
module swc_checker (
  input logic clk,
  input logic rst,
  input logic stop_req,
  input logic cfg_dret,
  input logic cfg_regen,
  input logic vdd_lt_warn,
  input logic vdd_lt_rst,
  input logic vdd_lt_por,
  input logic ext_rst,
  input logic cpu_run,
  input logic cpu_rst,
  input logic por_req,
  input logic pf_flag,
  input logic volatile_pd
);
  assert_stop_entry_R2: assert property (@(posedge clk) disable iff (rst)
    (cpu_run && stop_req && !vdd_lt_rst && !ext_rst)
      |=> (!cpu_run && (volatile_pd == $past(cfg_dret && !cfg_regen))));

  assert_por_follow_R8: assert property (@(posedge clk) disable iff (rst)
    vdd_lt_por |=> por_req);

  assert_run_fault_R12: assert property (@(posedge clk) disable iff (rst)
    (cpu_run && (vdd_lt_rst || ext_rst)) |=> (cpu_rst && cpu_run));

  assert_rst_at_run_R6: assert property (@(posedge clk) disable iff (rst)
    cpu_rst |-> cpu_run);

  assert_pf_cause_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(pf_flag) |-> $past(vdd_lt_warn));

  assert_por_exit_R7: assert property (@(posedge clk) disable iff (rst)
    (por_req && !$past(vdd_lt_por)) |-> cpu_run);
endmodule

bind stop_wake_ctrl swc_checker u_chk (
  .clk(clk), .rst(rst), .stop_req(stop_req), .cfg_dret(cfg_dret),
  .cfg_regen(cfg_regen), .vdd_lt_warn(vdd_lt_warn), .vdd_lt_rst(vdd_lt_rst),
  .vdd_lt_por(vdd_lt_por), .ext_rst(ext_rst), .cpu_run(cpu_run),
  .cpu_rst(cpu_rst), .por_req(por_req), .pf_flag(pf_flag),
  .volatile_pd(volatile_pd)
);

// File: tb/stop_wake_ctrl_tb.sv
`timescale 1ns/1ps
module stop_wake_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NIRQ = 4;
  localparam int TW   = 16;
  localparam int SET  = 4;
  localparam int OWW  = 8;

  logic clk = 0, rst = 1;
  logic stop_req = 0, cfg_dret = 0, cfg_regen = 0, cfg_pfd = 0, pfw_en = 0;
  logic [NIRQ-1:0] irq_en = '0, irq_req = '0;
  logic [TW-1:0] wake_period = '0;
  logic vdd_lt_warn = 0, vdd_lt_rst = 0, vdd_lt_por = 0, ext_rst = 0;
  logic ow_rst_pulse = 0, ow_pulse_od = 0, ow_addressed = 0, pf_clr = 0;
  logic cpu_run, pf_flag, cpu_rst, por_req, mon_en, volatile_pd, ow_pwr;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit cmp_on = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stop_wake_ctrl #(.NIRQ(NIRQ), .TMR_W(TW), .SETTLE_CYC(SET), .OW_WIN(OWW)) u_dut (
    .clk, .rst, .stop_req, .cfg_dret, .cfg_regen, .cfg_pfd, .pfw_en, .irq_en,
    .irq_req, .wake_period, .vdd_lt_warn, .vdd_lt_rst, .vdd_lt_por, .ext_rst,
    .ow_rst_pulse, .ow_pulse_od, .ow_addressed, .pf_clr, .cpu_run, .pf_flag,
    .cpu_rst, .por_req, .mon_en, .volatile_pd, .ow_pwr);

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference ----------------
  // phase: 0 running, 1 asleep, 2 listening, 3 exiting
  int  ph = 0, tmr = 0, left = 0;
  bit  keep = 0, moff = 0, xr = 0, e_rst = 0, e_por = 0, e_pf = 0;

  always @(posedge clk) begin
    if (rst) begin
      ph = 0; tmr = 0; left = 0; keep = 0; moff = 0; xr = 0;
      e_rst = 0; e_por = 0; e_pf = 0;
    end else begin
      bit sl, wk, fin, fault;
      int nph;
      sl    = (ph == 1) || (ph == 2);
      fault = vdd_lt_rst || ext_rst;
      wk = sl && ((irq_req & irq_en) != 0 || ext_rst || vdd_lt_por || tmr == 1
                  || (!moff && (vdd_lt_rst || (pfw_en && vdd_lt_warn)))
                  || (ph == 2 && ow_addressed));
      fin = (ph == 3) && (left == 1);
      e_rst = (ph == 0 && fault) || (fin && (vdd_lt_rst || xr || ext_rst));
      e_por = vdd_lt_por || (fin && keep);
      if ((ph == 0 || fin) && vdd_lt_warn) e_pf = 1;
      else if (pf_clr) e_pf = 0;
      if (ph != 0 && ext_rst) xr = 1;
      if (sl && tmr > 0) tmr--;
      nph = ph;
      if (ph == 0) begin
        if (stop_req && !fault) begin
          nph = 1; tmr = wake_period; keep = cfg_dret && !cfg_regen;
          moff = cfg_pfd; xr = 0;
        end
      end else if (ph == 3) begin
        if (left == 1) nph = 0; else left--;
      end else if (wk) begin
        nph = 3; left = SET;
      end else if (ph == 1) begin
        if (ow_rst_pulse && !ow_pulse_od) begin nph = 2; left = OWW; end
      end else begin
        if (left == 1) nph = 1; else left--;
      end
      ph = nph;
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      bit sl;
      sl = (ph == 1) || (ph == 2);
      chk("R5 model cpu_run", cpu_run, ph == 0);
      chk("R4 model mon_en", mon_en, ph == 0 || ph == 3 || (sl && !moff));
      chk("R10 model ow_pwr", ow_pwr, ph != 1);
      chk("R2 model volatile_pd", volatile_pd, sl && keep);
      chk("R6 model cpu_rst", cpu_rst, e_rst);
      chk("R8 model por_req", por_req, e_por);
      chk("R12 model pf_flag", pf_flag, e_pf);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  // ---------------- directed stimulus ----------------
  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic enter(input bit d, input bit g, input bit p, input int per);
    cfg_dret = d; cfg_regen = g; cfg_pfd = p; wake_period = TW'(per);
    stop_req = 1; tick(); stop_req = 0;
  endtask

  initial begin
    tick(3);
    rst = 0;
    tick();
    cmp_on = 1;
    chk("R1 cpu_run", cpu_run, 1);   chk("R1 mon_en", mon_en, 1);
    chk("R1 ow_pwr", ow_pwr, 1);     chk("R1 volatile_pd", volatile_pd, 0);
    chk("R1 cpu_rst", cpu_rst, 0);   chk("R1 por_req", por_req, 0);
    chk("R1 pf_flag", pf_flag, 0);

    // plain stop, interrupt wake, masked line first
    irq_en = 4'b0010;
    enter(0, 0, 0, 0);
    chk("R2 cpu_run low", cpu_run, 0); chk("R2 ow_pwr low", ow_pwr, 0);
    chk("R2 mon_en kept", mon_en, 1);  chk("R2 plain no pd", volatile_pd, 0);
    irq_req = 4'b0001; tick(); irq_req = 0;
    chk("R13 masked irq stays asleep", mon_en + ow_pwr + cpu_run, 1);
    tick(2);
    irq_req = 4'b0010; tick(); irq_req = 0;
    chk("R3 irq wake ow_pwr", ow_pwr, 1); chk("R3 irq wake cpu_run", cpu_run, 0);
    tick(SET - 1);
    chk("R5 still settling", cpu_run, 0);
    tick();
    chk("R5 released", cpu_run, 1); chk("R7 plain exit no por", por_req, 0);

    // retention stop, timer wake
    enter(1, 0, 0, 5);
    chk("R2 retention pd", volatile_pd, 1);
    tick(4);
    chk("R9 asleep at cycle P", volatile_pd, 1);
    tick();
    chk("R9 timer wake", volatile_pd, 0); chk("R3 exit mon_en", mon_en, 1);
    tick(SET);
    chk("R7 retention por", por_req, 1); chk("R7 running", cpu_run, 1);
    tick();
    chk("R7 por one cycle", por_req, 0);

    // regulator kept on: no retention
    enter(1, 1, 0, 3);
    chk("R2 regen blocks retention", volatile_pd, 0);
    tick(3 + SET);
    chk("R9 plain timer exit", cpu_run, 1);

    // monitor off: warn/rst ignored, por still wakes
    pfw_en = 1;
    enter(0, 0, 1, 0);
    chk("R4 mon_en off", mon_en, 0);
    vdd_lt_warn = 1; vdd_lt_rst = 1; tick(10);
    chk("R4 ignored comparators", cpu_run + ow_pwr, 0);
    chk("R9 period zero no wake", mon_en, 0);
    vdd_lt_warn = 0; vdd_lt_rst = 0; tick();
    vdd_lt_por = 1; tick(); vdd_lt_por = 0;
    chk("R8 por pulse", por_req, 1); chk("R4 por wakes", mon_en, 1);
    tick(SET);
    chk("R4 back to run", cpu_run, 1); chk("R7 plain por absent", por_req, 0);

    // warning wake with flag at exit, then clear
    enter(0, 0, 0, 0);
    vdd_lt_warn = 1; tick();
    chk("R3 warn wake", ow_pwr, 1);
    tick(SET);
    chk("R6 pf at exit", pf_flag, 1);
    vdd_lt_warn = 0; tick();
    pf_clr = 1; tick(); pf_clr = 0;
    chk("R12 pf cleared", pf_flag, 0);

    // bus wake path in retention
    enter(1, 0, 0, 0);
    ow_rst_pulse = 1; ow_pulse_od = 1; tick(); ow_rst_pulse = 0; ow_pulse_od = 0;
    chk("R11 overdrive ignored", ow_pwr, 0);
    ow_rst_pulse = 1; tick(); ow_rst_pulse = 0;
    chk("R10 listen power", ow_pwr, 1); chk("R10 cpu held", cpu_run, 0);
    tick(OWW - 1);
    chk("R10 window last cycle", ow_pwr, 1);
    tick();
    chk("R10 unaddressed back to stop", ow_pwr, 0);
    chk("R10 retention kept", volatile_pd, 1);
    ow_rst_pulse = 1; tick(); ow_rst_pulse = 0;
    tick(2);
    ow_addressed = 1; tick(); ow_addressed = 0;
    chk("R10 addressed wake", volatile_pd, 0);
    tick(SET);
    chk("R10 running", cpu_run, 1); chk("R7 bus exit por", por_req, 1);

    // external reset wake in retention
    enter(1, 0, 0, 0);
    ext_rst = 1; tick(); ext_rst = 0;
    chk("R3 ext wake", mon_en, 1);
    tick(SET);
    chk("R6 ext reset at exit", cpu_rst, 1);
    tick();
    chk("R6 reset one cycle", cpu_rst, 0);

    // reset-threshold wake, still low at judgement
    enter(0, 0, 0, 0);
    vdd_lt_rst = 1; tick();
    chk("R3 rst wake", ow_pwr, 1);
    tick(SET);
    chk("R6 cpu reset at exit", cpu_rst, 1);
    vdd_lt_rst = 0; tick(2);
    chk("R6 reset released", cpu_rst, 0);

    // running fault drops stop request
    stop_req = 1; ext_rst = 1; tick(); stop_req = 0; ext_rst = 0;
    chk("R12 stop dropped", cpu_run, 1); chk("R12 run reset", cpu_rst, 1);
    tick(2);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule